// File: doc/BRIEF.md
# Reversible Binary Counter with Preset and Cascade Outputs

A synchronous binary counter whose state bits all change together on the rising clock edge. One direction line chooses between counting up and counting down. An active-low enable gates counting. An active-low preset copies a data word onto the outputs at once, whatever the clock is doing. If the preset value is chosen as the count length, the counter works as a divide-by-N stage.

Two outputs let counters be chained. The terminal flag goes high while the count sits at the value it leaves on overflow (all ones when counting up) or on underflow (all zeros when counting down). The active-low ripple output pulses during the low half of the clock while the terminal flag is high and counting is enabled. It can drive the enable of a next stage that shares the clock, or the clock of a next stage that shares the enable. A synchronous active-high reset clears the count.

Top module: `updown_counter`

## Requirements
- R1: With `load_n` high, `rst` high at a rising clock edge sets `q` to zero.
- R2: With `enable_n` high (and `load_n` high, `rst` low), `q` keeps its value across a rising clock edge.
- R3: With `enable_n` low and `down_up` = 0, each rising edge adds one to `q`; all ones wraps to zero.
- R4: With `enable_n` low and `down_up` = 1, each rising edge subtracts one from `q`; zero wraps to all ones.
- R5: While `load_n` is low, `q` equals `d` within the same time step, during either clock phase. After `load_n` returns high, `q` keeps that value, provided `d` was held steady while `load_n` was low.
- R6: A low `load_n` at a rising edge overrides counting and reset: `q` stays equal to `d`.
- R7: `max_min` is 1 exactly when `down_up` = 0 and `q` is all ones, or when `down_up` = 1 and `q` is zero. It follows `q` and `down_up` without waiting for a clock.
- R8: `ripple_n` is 0 only while `clk` is low, `max_min` is 1 and `enable_n` is 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active; its low phase gates `ripple_n` |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low asynchronous preset from `d` |
| enable_n | input | 1 | Active-low count enable |
| down_up | input | 1 | Direction: 0 up, 1 down |
| d | input | W (4) | Preset value |
| q | output | W (4) | Counter state |
| max_min | output | 1 | Terminal-count flag for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse in the clock low phase |

## Verification
The hardest case to reach is the ripple pulse: it needs the terminal value and the matching direction together with an enabled count, and it exists only in the clock's low half. The bench presets every value from 0 to 15 and then steps once for each combination of direction and enable. For every step it samples `ripple_n` once in the high phase and once in the low phase. The preset is applied in both clock phases, and it is also held across edges that carry an active enable and an active reset, to show that it takes priority.

// File: rtl/udc_pkg.sv
`timescale 1ns/1ps
package udc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } udc_dir_e;
endpackage

// File: rtl/udc_step.sv
`timescale 1ns/1ps
// Next-state arithmetic: add or subtract one, or keep the value.
module udc_step
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  udc_dir_e     dir,
  input  logic         advance,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (!advance)           nxt = cur;
    else if (dir == DIR_UP) nxt = cur + ONE;
    else                    nxt = cur - ONE;
  end
endmodule

// File: rtl/udc_term.sv
`timescale 1ns/1ps
// Terminal decode: all ones going up, all zeros going down.
module udc_term
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  udc_dir_e     dir,
  output logic         at_term
);
  logic all_one;
  logic all_zero;

  assign all_one  = &cur;
  assign all_zero = ~|cur;
  assign at_term  = (dir == DIR_UP) ? all_one : all_zero;
endmodule

// File: rtl/udc_ripple.sv
`timescale 1ns/1ps
// Cascade pulse: low for the low half of the clock while terminal and enabled.
module udc_ripple (
  input  logic clk,
  input  logic at_term,
  input  logic enable_n,
  output logic ripple_n
);
  assign ripple_n = ~(at_term & ~enable_n & ~clk);
endmodule

// File: rtl/updown_counter.sv
`timescale 1ns/1ps
module updown_counter
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         enable_n,
  input  logic         down_up,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         max_min,
  output logic         ripple_n
);
  udc_dir_e     dir;
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;

  assign dir = udc_dir_e'(down_up);

  udc_step #(.W(W)) u_step (
    .cur     (cnt_r),
    .dir     (dir),
    .advance (~enable_n),
    .nxt     (cnt_nxt)
  );

  // Preset acts at once; the clocked path handles reset and counting.
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)  cnt_r <= d;
    else if (rst) cnt_r <= '0;
    else          cnt_r <= cnt_nxt;
  end

  // While the preset is held, the outputs follow the data word directly.
  assign q = load_n ? cnt_r : d;

  udc_term #(.W(W)) u_term (
    .cur     (q),
    .dir     (dir),
    .at_term (max_min)
  );

  udc_ripple u_ripple (
    .clk      (clk),
    .at_term  (max_min),
    .enable_n (enable_n),
    .ripple_n (ripple_n)
  );
endmodule

// File: rtl/udc_checker.sv
`timescale 1ns/1ps
module udc_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         load_n,
  input logic         enable_n,
  input logic         down_up,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         max_min,
  input logic         ripple_n
);
  localparam logic [W-1:0] ONE = W'(1);

  // Set when a preset occurred since the previous rising edge.
  logic ld_mark;
  logic primed;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) ld_mark <= 1'b1;
    else         ld_mark <= 1'b0;
  end

  always_ff @(posedge clk) primed <= !rst;

  a_r1_clear: assert property (@(posedge clk)
    (rst && load_n) |=> (ld_mark || q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (primed && !ld_mark && load_n && $past(enable_n)) |-> q == $past(q));

  a_r3_up: assert property (@(posedge clk) disable iff (rst)
    (primed && !ld_mark && load_n && !$past(enable_n) && !$past(down_up))
      |-> q == $past(q) + ONE);

  a_r4_down: assert property (@(posedge clk) disable iff (rst)
    (primed && !ld_mark && load_n && !$past(enable_n) && $past(down_up))
      |-> q == $past(q) - ONE);

  a_r5_preset: assert property (@(posedge clk) !load_n |-> q == d);

  a_r7_tc_then_wrap: assert property (@(posedge clk) disable iff (rst)
    (primed && !ld_mark && load_n && $past(max_min) && !$past(enable_n)
      && !$past(down_up)) |-> q == '0);

  a_r8_idle_high: assert property (@(posedge clk) enable_n |-> ripple_n);

  a_r8_needs_tc: assert property (@(posedge clk) !ripple_n |-> max_min);
endmodule

bind updown_counter udc_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_n   (load_n),
  .enable_n (enable_n),
  .down_up  (down_up),
  .d        (d),
  .q        (q),
  .max_min  (max_min),
  .ripple_n (ripple_n)
);

// File: tb/test_updown_counter.sv
`timescale 1ns/1ps
module test_updown_counter;
  logic       clk = 1'b0;
  logic       rst;
  logic       load_n;
  logic       enable_n;
  logic       down_up;
  logic [3:0] d;
  logic [3:0] q;
  logic       max_min;
  logic       ripple_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [3:0] exp_q;

  always #10 clk = ~clk;

  updown_counter #(.W(4)) i_updown_counter (
    .clk(clk), .rst(rst), .load_n(load_n), .enable_n(enable_n),
    .down_up(down_up), .d(d), .q(q), .max_min(max_min), .ripple_n(ripple_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Entered 2 ns after a rising edge; returns 2 ns after the next one.
  task automatic do_load(input logic [3:0] v, input bit high_phase);
    enable_n = 1'b1;
    if (high_phase) #1; else #10;
    d = v; load_n = 1'b0;
    #1 chk(q == v, "R5", "q during preset", q, v);
    load_n = 1'b1;
    #1 chk(q == v, "R5", "q after preset", q, v);
    @(posedge clk); #2;
    chk(q == v, "R2", "hold after preset", q, v);
    exp_q = v;
  endtask

  task automatic tick(input bit en_n, input bit dir);
    bit mm;
    enable_n = en_n; down_up = dir;
    mm = dir ? (exp_q == 4'd0) : (exp_q == 4'd15);
    #1;
    chk(max_min == mm, "R7", "max_min", max_min, mm);
    chk(ripple_n == 1'b1, "R8", "ripple_n clock high", ripple_n, 1);
    #10;
    chk(ripple_n == !(mm && !en_n), "R8", "ripple_n clock low", ripple_n, !(mm && !en_n));
    @(posedge clk);
    if (!en_n) exp_q = dir ? exp_q - 4'd1 : exp_q + 4'd1;
    #2;
    if (en_n)      chk(q == exp_q, "R2", "hold", q, exp_q);
    else if (!dir) chk(q == exp_q, "R3", "count up", q, exp_q);
    else           chk(q == exp_q, "R4", "count down", q, exp_q);
  endtask

  initial begin
    rst = 1'b1; load_n = 1'b1; enable_n = 1'b1; down_up = 1'b0; d = 4'd0;
    repeat (3) @(posedge clk);
    #2;
    chk(q == 4'd0, "R1", "q after reset", q, 0);
    chk(max_min == 1'b0, "R7", "max_min after reset", max_min, 0);
    chk(ripple_n == 1'b1, "R8", "ripple_n after reset", ripple_n, 1);
    rst = 1'b0;
    exp_q = 4'd0;

    for (int v = 0; v < 16; v++)
      for (int dir = 0; dir < 2; dir++)
        for (int en = 0; en < 2; en++) begin
          do_load(4'(v), (v % 2) == 1);
          tick(en[0], dir[0]);
        end

    do_load(4'd0, 1'b0);
    repeat (20) tick(1'b0, 1'b0);
    repeat (20) tick(1'b0, 1'b1);
    repeat (3)  tick(1'b1, 1'b0);

    // R6: preset held across edges with counting enabled, then with reset
    enable_n = 1'b0; down_up = 1'b0; d = 4'd9; load_n = 1'b0;
    @(posedge clk); #2;
    chk(q == 4'd9, "R6", "preset beats count", q, 9);
    rst = 1'b1;
    @(posedge clk); #2;
    chk(q == 4'd9, "R6", "preset beats reset", q, 9);
    rst = 1'b0; load_n = 1'b1; exp_q = 4'd9;
    tick(1'b0, 1'b0);

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk); #2;
    chk(q == 4'd0, "R1", "mid-run reset", q, 0);
    rst = 1'b0; exp_q = 4'd0;
    tick(1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule